// File: doc/BRIEF.md
# Split Shifted 64-bit Pointer Adder

This block adds a 64-bit base pointer to an offset that is first shifted left by a small immediate of 0 to 7 bits. It is built as two 32-bit halves. The low-half unit adds the low word of the base to the low word of the shifted offset. The high-half unit completes the upper word. The carry, the offset bits pushed out of the low word by the shift, the shift amount and the offset's sign bit all pass from the low unit to the high unit on a private sideband. None of them goes through the operand interface. Both halves work on the same operation in the same cycle.

The offset can be interpreted in three ways. It can be a full 64-bit value, an unsigned 32-bit value that is zero-extended, or a signed 32-bit value that is sign-extended. In the two 32-bit modes the upper word of the offset input is not used. The combined 64-bit sum is registered and appears one cycle after the request, together with a valid strobe.

Top module: `split_ptr_adder`

## Requirements
- R1: While rst_ni is low, valid_o is 0 and result_o is 0.
- R2: valid_o equals the value valid_i had at the previous rising clock edge.
- R3: With mode_i = 2'b00 (64-bit offset), the result one cycle after an accepted request is (base_i + (offset_i << shift_i)) mod 2^64.
- R4: With mode_i = 2'b01 (unsigned 32-bit offset), the result is (base_i + ({32'b0, offset_i[31:0]} << shift_i)) mod 2^64.
- R5: With mode_i = 2'b10 (signed 32-bit offset), the result is (base_i + (sign-extended offset_i[31:0] << shift_i)) mod 2^64.
- R6: mode_i = 2'b11 gives the same result as 2'b01.
- R7: In the 32-bit modes, offset_i[63:32] has no effect on result_o.
- R8: Every shift value from 0 to 7 is applied exactly. This includes shift 0, where no offset bits cross into the upper word, and shift 7, where seven bits cross. A carry out of the low word is added into the upper word.
- R9: In a cycle where valid_i is low, result_o keeps its previous value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | Request strobe |
| mode_i | input | 2 | Offset interpretation: 00 64-bit, 01 unsigned 32-bit, 10 signed 32-bit, 11 same as 01 |
| shift_i | input | 3 | Left shift applied to the offset, 0 to 7 |
| base_i | input | 64 | Base pointer |
| offset_i | input | 64 | Offset; only bits 31:0 are used in the 32-bit modes |
| valid_o | output | 1 | Result strobe, one cycle after valid_i |
| result_o | output | 64 | Registered 64-bit sum |

## Verification
The bound checker checks these properties on every cycle:
- the reset state;
- the one-cycle valid pipeline;
- that the result holds while idle;
- the sum in every mode, against a flat 64-bit expression, which covers R3 to R6 whatever the inputs are.

Some behaviours are only shown by the bench's scenarios, because they compare two separate requests:
- that the upper offset word is ignored, shown by sending the same low word with different upper words and getting the same result;
- the carry and spill boundaries, shown by shift 0 and shift 7 with all-ones and sign-bit patterns.

// File: rtl/ptr_add_pkg.sv
package ptr_add_pkg;
  localparam int unsigned HALF_W  = 32;
  localparam int unsigned SHIFT_W = 3;

  typedef enum logic [1:0] {
    OFS_FULL64 = 2'b00,
    OFS_ZEXT32 = 2'b01,
    OFS_SEXT32 = 2'b10,
    OFS_ALIAS  = 2'b11
  } ofs_mode_e;

  typedef enum logic [1:0] {
    HI_SRC_FULL,
    HI_SRC_ZERO,
    HI_SRC_SIGN
  } hi_src_e;

  // 11 folds onto the unsigned 32-bit path
  function automatic hi_src_e decode_mode(input logic [1:0] m);
    case (ofs_mode_e'(m))
      OFS_FULL64: return HI_SRC_FULL;
      OFS_SEXT32: return HI_SRC_SIGN;
      default:    return HI_SRC_ZERO;
    endcase
  endfunction
endpackage

// File: rtl/ptr_add_lo.sv
module ptr_add_lo #(
  parameter int unsigned HALF_W  = 32,
  parameter int unsigned SHIFT_W = 3,
  localparam int unsigned SPILL_W = (1 << SHIFT_W) - 1
) (
  input  logic [HALF_W-1:0]  base_lo_i,
  input  logic [HALF_W-1:0]  ofs_lo_i,
  input  logic [SHIFT_W-1:0] shift_i,
  output logic [HALF_W-1:0]  sum_lo_o,
  // sideband to the high unit
  output logic               sb_carry_o,
  output logic [SPILL_W-1:0] sb_spill_o,
  output logic [SHIFT_W-1:0] sb_shift_o,
  output logic               sb_sign_o
);
  logic [HALF_W+SPILL_W-1:0] ofs_wide;
  logic [HALF_W:0]           sum_ext;

  always_comb begin
    ofs_wide = {{SPILL_W{1'b0}}, ofs_lo_i} << shift_i;
    sum_ext  = {1'b0, base_lo_i} + {1'b0, ofs_wide[HALF_W-1:0]};
  end

  assign sum_lo_o   = sum_ext[HALF_W-1:0];
  assign sb_carry_o = sum_ext[HALF_W];
  assign sb_spill_o = ofs_wide[HALF_W+SPILL_W-1:HALF_W];
  assign sb_shift_o = shift_i;
  assign sb_sign_o  = ofs_lo_i[HALF_W-1];
endmodule

// File: rtl/ptr_add_hi.sv
module ptr_add_hi
  import ptr_add_pkg::*;
#(
  parameter int unsigned HALF_W  = 32,
  parameter int unsigned SHIFT_W = 3,
  localparam int unsigned SPILL_W = (1 << SHIFT_W) - 1
) (
  input  logic [HALF_W-1:0]  base_hi_i,
  input  logic [HALF_W-1:0]  ofs_hi_i,
  input  hi_src_e            hi_src_i,
  input  logic               sb_carry_i,
  input  logic [SPILL_W-1:0] sb_spill_i,
  input  logic [SHIFT_W-1:0] sb_shift_i,
  input  logic               sb_sign_i,
  output logic [HALF_W-1:0]  sum_hi_o
);
  logic [HALF_W-1:0] spill_w;
  logic [HALF_W-1:0] upper_src;
  logic [HALF_W-1:0] addend;
  logic [HALF_W:0]   sum_ext;

  assign spill_w = {{(HALF_W-SPILL_W){1'b0}}, sb_spill_i};

  always_comb begin
    unique case (hi_src_i)
      HI_SRC_FULL: upper_src = ofs_hi_i;
      HI_SRC_SIGN: upper_src = {HALF_W{sb_sign_i}};
      default:     upper_src = '0;
    endcase
    addend  = (upper_src << sb_shift_i) | spill_w;
    sum_ext = {1'b0, base_hi_i} + {1'b0, addend} + {{HALF_W{1'b0}}, sb_carry_i};
  end

  assign sum_hi_o = sum_ext[HALF_W-1:0];
endmodule

// File: rtl/split_ptr_adder.sv
module split_ptr_adder
  import ptr_add_pkg::*;
#(
  parameter int unsigned HALF_W  = ptr_add_pkg::HALF_W,
  parameter int unsigned SHIFT_W = ptr_add_pkg::SHIFT_W,
  localparam int unsigned FULL_W  = 2 * HALF_W,
  localparam int unsigned SPILL_W = (1 << SHIFT_W) - 1
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               valid_i,
  input  logic [1:0]         mode_i,
  input  logic [SHIFT_W-1:0] shift_i,
  input  logic [FULL_W-1:0]  base_i,
  input  logic [FULL_W-1:0]  offset_i,
  output logic               valid_o,
  output logic [FULL_W-1:0]  result_o
);
  logic [HALF_W-1:0]  sum_lo, sum_hi;
  logic               sb_carry, sb_sign;
  logic [SPILL_W-1:0] sb_spill;
  logic [SHIFT_W-1:0] sb_shift;
  hi_src_e            hi_src;

  assign hi_src = decode_mode(mode_i);

  ptr_add_lo #(.HALF_W(HALF_W), .SHIFT_W(SHIFT_W)) u_lo (
    .base_lo_i  (base_i[HALF_W-1:0]),
    .ofs_lo_i   (offset_i[HALF_W-1:0]),
    .shift_i    (shift_i),
    .sum_lo_o   (sum_lo),
    .sb_carry_o (sb_carry),
    .sb_spill_o (sb_spill),
    .sb_shift_o (sb_shift),
    .sb_sign_o  (sb_sign)
  );

  ptr_add_hi #(.HALF_W(HALF_W), .SHIFT_W(SHIFT_W)) u_hi (
    .base_hi_i  (base_i[FULL_W-1:HALF_W]),
    .ofs_hi_i   (offset_i[FULL_W-1:HALF_W]),
    .hi_src_i   (hi_src),
    .sb_carry_i (sb_carry),
    .sb_spill_i (sb_spill),
    .sb_shift_i (sb_shift),
    .sb_sign_i  (sb_sign),
    .sum_hi_o   (sum_hi)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o  <= 1'b0;
      result_o <= '0;
    end else begin
      valid_o <= valid_i;
      if (valid_i) result_o <= {sum_hi, sum_lo};
    end
  end
endmodule

// File: rtl/split_ptr_adder_chk.sv
module split_ptr_adder_chk #(
  parameter int unsigned HALF_W  = 32,
  parameter int unsigned SHIFT_W = 3,
  localparam int unsigned FULL_W = 2 * HALF_W
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic               valid_i,
  input logic [1:0]         mode_i,
  input logic [SHIFT_W-1:0] shift_i,
  input logic [FULL_W-1:0]  base_i,
  input logic [FULL_W-1:0]  offset_i,
  input logic               valid_o,
  input logic [FULL_W-1:0]  result_o
);
  logic [FULL_W-1:0] zext_ofs, sext_ofs;
  assign zext_ofs = {{HALF_W{1'b0}}, offset_i[HALF_W-1:0]};
  assign sext_ofs = {{HALF_W{offset_i[HALF_W-1]}}, offset_i[HALF_W-1:0]};

  // R1
  reset_state_chk: assert property (@(posedge clk_i)
    !rst_ni |-> (!valid_o && result_o == '0));

  // R2
  valid_pipe_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i |=> valid_o);

  // R2
  valid_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> !valid_o);

  // R3
  full64_sum_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && mode_i == 2'b00) |=>
      result_o == $past(base_i + (offset_i << shift_i)));

  // R4 R6
  zext_sum_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && mode_i[0]) |=>
      result_o == $past(base_i + (zext_ofs << shift_i)));

  // R5
  sext_sum_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && mode_i == 2'b10) |=>
      result_o == $past(base_i + (sext_ofs << shift_i)));

  // R9
  hold_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> $stable(result_o));
endmodule

bind split_ptr_adder split_ptr_adder_chk #(.HALF_W(HALF_W), .SHIFT_W(SHIFT_W)) u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .valid_i  (valid_i),
  .mode_i   (mode_i),
  .shift_i  (shift_i),
  .base_i   (base_i),
  .offset_i (offset_i),
  .valid_o  (valid_o),
  .result_o (result_o)
);

// File: tb/split_ptr_adder_bench.sv
`timescale 1ns/1ps
module split_ptr_adder_bench;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        valid_i = 1'b0;
  logic [1:0]  mode_i = '0;
  logic [2:0]  shift_i = '0;
  logic [63:0] base_i = '0;
  logic [63:0] offset_i = '0;
  logic        valid_o;
  logic [63:0] result_o;

  int n_vec = 0;
  int n_bad = 0;
  bit done = 1'b0;
  logic [63:0] last_exp = '0;

  always #2.5 clk_i = ~clk_i;

  split_ptr_adder u_split_ptr_adder (
    .clk_i, .rst_ni, .valid_i, .mode_i, .shift_i,
    .base_i, .offset_i, .valid_o, .result_o
  );

  function automatic logic [63:0] ref_sum(input logic [1:0] m, input logic [2:0] sh,
                                          input logic [63:0] a, input logic [63:0] b);
    longint unsigned ofs;
    case (m)
      2'b00:   ofs = b;
      2'b10:   ofs = longint'(signed'(b[31:0]));
      default: ofs = {32'h0, b[31:0]};
    endcase
    return a + (ofs << sh);
  endfunction

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  // drive at negedge, sample one cycle later at negedge
  task automatic apply(input string req, input logic [1:0] m, input logic [2:0] sh,
                       input logic [63:0] a, input logic [63:0] b);
    valid_i = 1'b1; mode_i = m; shift_i = sh; base_i = a; offset_i = b;
    last_exp = ref_sum(m, sh, a, b);
    @(negedge clk_i);
    check({req, " valid"}, {63'h0, valid_o}, 64'h1);
    check(req, result_o, last_exp);
  endtask

  task automatic idle(input string req);
    valid_i = 1'b0; base_i = 64'hdead_beef_0bad_f00d; offset_i = 64'h1234;
    @(negedge clk_i);
    check({req, " valid low"}, {63'h0, valid_o}, 64'h0);
    check({req, " hold"}, result_o, last_exp);
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

  initial begin
    logic [63:0] r_a, r_b;
    repeat (2) @(negedge clk_i);
    check("R1 valid", {63'h0, valid_o}, 64'h0);
    check("R1 result", result_o, 64'h0);
    rst_ni = 1'b1;
    @(negedge clk_i);
    check("R2 idle after reset", {63'h0, valid_o}, 64'h0);

    // R3 full 64-bit, carry and spill
    apply("R3 basic", 2'b00, 3'd0, 64'h1, 64'h2);
    apply("R3 R8 carry", 2'b00, 3'd0, 64'h0000_0000_ffff_ffff, 64'h1);
    apply("R3 R8 sh7", 2'b00, 3'd7, 64'h0123_4567_89ab_cdef, 64'hffff_ffff_ffff_ffff);
    apply("R3 R8 spill", 2'b00, 3'd7, 64'h0, 64'h0000_0001_fe00_0000);
    // R4 unsigned 32
    apply("R4 zext", 2'b01, 3'd3, 64'h0000_0010_ffff_fff0, 64'hffff_ffff_8000_0001);
    apply("R4 R8 sh0", 2'b01, 3'd0, 64'h0000_0000_ffff_ffff, 64'h5555_5555_0000_0001);
    // R5 signed 32
    apply("R5 sext neg", 2'b10, 3'd2, 64'h0000_0100_0000_0000, 64'h0000_0000_ffff_fffc);
    apply("R5 R8 sh7", 2'b10, 3'd7, 64'h8000_0000_0000_0000, 64'h1111_1111_8000_0000);
    apply("R5 pos", 2'b10, 3'd5, 64'h10, 64'hffff_ffff_7fff_ffff);
    // R6 alias
    apply("R6 alias", 2'b11, 3'd4, 64'h0000_0000_f000_0000, 64'hffff_ffff_8000_0000);
    // R9 hold
    idle("R9");
    idle("R2 R9");

    // R7: upper offset word ignored in 32-bit modes
    for (int m = 1; m < 4; m++) begin
      apply("R7 ref", 2'(m), 3'd6, 64'h0abc_0000_7fff_ffff, 64'h0000_0000_c000_0003);
      r_a = result_o;
      apply("R7 hi changed", 2'(m), 3'd6, 64'h0abc_0000_7fff_ffff, 64'hffff_0000_c000_0003);
      check("R7 same result", result_o, r_a);
    end

    // R8 sweep all shifts and modes, back-to-back
    for (int s = 0; s < 8; s++)
      for (int m = 0; m < 4; m++) begin
        r_a = {$urandom, $urandom};
        r_b = {$urandom, $urandom};
        apply("R8 sweep", 2'(m), 3'(s), r_a, r_b);
      end
    idle("R9 end");

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule